// File: doc/BRIEF.md
# Stack Machine Two-Operand ALU

This block is the arithmetic and logic unit of a 32-bit stack processor. The core hands it the value on top of the stack (A, popped first), the value beneath it (B) and an 8-bit operation code, and pulses a start strobe. Exactly one clock later the unit returns a registered result with a done strobe. It also reports whether the operation used one or both stack entries, so the core knows how far to move its stack pointer before pushing the result.

The operation set follows stack-machine conventions rather than register-file ones. Subtraction takes B minus A. Compares yield the integer 0 or 1. A bit-mirror operation is included. Shift amounts come from the low six bits of A, so amounts from 32 to 63 have a defined result. Any code outside the set returns zero and raises an illegal-operation flag.

Top module: `stk_alu`

## Requirements
- R1: `done` is high in exactly the cycle after a cycle with `start` high, and low otherwise. `result`, `pops_two` and `bad_op` change only on such a cycle and hold their values between operations.
- R2: Add (code 0x05) returns A+B and subtract (code 49) returns B−A. Negate (code 48) returns −A. All of these wrap modulo 2^32.
- R3: And (0x06), or (0x07) and xor (50) return the bitwise combination of A and B. Not (0x09) returns the bitwise inverse of A.
- R4: Bit-reverse (0x0A) mirrors A, so that result bit i equals A bit 31−i.
- R5: Signed less-than (36) returns 1 when A<B as two's-complement values, and 0 otherwise. Signed less-or-equal (37) returns 1 when A<=B.
- R6: Unsigned less-than (38) and unsigned less-or-equal (39) compare A against B as unsigned values and return 1 or 0.
- R7: Equal (46) returns 1 when A==B, and not-equal (47) returns 1 when A!=B. Otherwise each returns 0.
- R8: Multiply (41) returns the low 32 bits of the signed product of A and B.
- R9: Logical right shift (42) and left shift (43) move B by A[5:0] places and ignore A[31:6]. An amount of 32 to 63 gives 0.
- R10: Arithmetic right shift (44) moves B right by A[5:0] places and fills from B's sign bit. An amount of 32 or more gives all sign bits.
- R11: `pops_two` is 0 for not, negate and bit-reverse, which use only A. It is 1 for every other legal code.
- R12: A code not listed above gives `result` = 0, `bad_op` = 1 and `pops_two` = 0. Every legal code gives `bad_op` = 0.
- R13: While `rst_n` is low, `done`, `result`, `pops_two` and `bad_op` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation this cycle |
| op | input | 8 | Operation code |
| tos | input | W | Operand A, the top of stack |
| nos | input | W | Operand B, the next entry down |
| done | output | 1 | Result valid, one cycle after start |
| result | output | W | Operation result |
| pops_two | output | 1 | 1 when both operands are consumed |
| bad_op | output | 1 | Unrecognised operation code |

## Verification
Each operation is driven with an ordinary case and with a case that exposes a likely fault.

- Subtraction and the compares are run with the operands in both orders. This catches a swapped A and B.
- The signed and unsigned compares share the pair −1 and 1, which separates the two signednesses.
- Shifts use amounts of 0x40 and 0x41. These show whether bits above the six-bit field are masked off. Amounts of 32, 40 and 63 confirm the zero fill and the sign fill.
- The multiply uses a negative factor, and also a product whose low 32 bits are zero.
- Idle cycles after an operation show that the outputs hold and that `done` falls again.

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [7:0]   op,
  input  logic [W-1:0] tos,
  input  logic [W-1:0] nos,
  output logic         done,
  output logic [W-1:0] result,
  output logic         pops_two,
  output logic         bad_op
);
  localparam int SHW = $clog2(W) + 1;

  localparam logic [7:0] C_ADD = 8'd5,  C_AND = 8'd6,  C_OR  = 8'd7,  C_NOT = 8'd9;
  localparam logic [7:0] C_REV = 8'd10, C_LT  = 8'd36, C_LE  = 8'd37, C_ULT = 8'd38;
  localparam logic [7:0] C_ULE = 8'd39, C_MUL = 8'd41, C_SRL = 8'd42, C_SLL = 8'd43;
  localparam logic [7:0] C_SRA = 8'd44, C_EQ  = 8'd46, C_NE  = 8'd47, C_NEG = 8'd48;
  localparam logic [7:0] C_SUB = 8'd49, C_XOR = 8'd50;

  logic [SHW-1:0] amt;
  logic [W-1:0]   mirror, nxt_res;
  logic           nxt_two, nxt_bad;

  assign amt = tos[SHW-1:0];

  always_comb
    for (int i = 0; i < W; i++) mirror[i] = tos[W-1-i];

  function automatic logic [W-1:0] flag(input logic c);
    return {{(W-1){1'b0}}, c};
  endfunction

  always_comb begin
    nxt_res = '0;
    nxt_two = 1'b1;
    nxt_bad = 1'b0;
    case (op)
      C_ADD: nxt_res = tos + nos;
      C_SUB: nxt_res = nos - tos;
      C_NEG: begin nxt_res = -tos; nxt_two = 1'b0; end
      C_AND: nxt_res = tos & nos;
      C_OR:  nxt_res = tos | nos;
      C_XOR: nxt_res = tos ^ nos;
      C_NOT: begin nxt_res = ~tos; nxt_two = 1'b0; end
      C_REV: begin nxt_res = mirror; nxt_two = 1'b0; end
      C_LT:  nxt_res = flag($signed(tos) <  $signed(nos));
      C_LE:  nxt_res = flag($signed(tos) <= $signed(nos));
      C_ULT: nxt_res = flag(tos <  nos);
      C_ULE: nxt_res = flag(tos <= nos);
      C_EQ:  nxt_res = flag(tos == nos);
      C_NE:  nxt_res = flag(tos != nos);
      C_MUL: nxt_res = tos * nos;
      C_SRL: nxt_res = nos >> amt;
      C_SLL: nxt_res = nos << amt;
      C_SRA: nxt_res = W'($signed(nos) >>> amt);
      default: begin nxt_two = 1'b0; nxt_bad = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      result   <= '0;
      pops_two <= 1'b0;
      bad_op   <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        result   <= nxt_res;
        pops_two <= nxt_two;
        bad_op   <= nxt_bad;
      end
    end
  end

  logic is_cmp, is_unary;
  assign is_cmp   = (op == C_LT) || (op == C_LE) || (op == C_ULT) || (op == C_ULE) ||
                    (op == C_EQ) || (op == C_NE);
  assign is_unary = (op == C_NOT) || (op == C_NEG) || (op == C_REV);

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start |=> done); // R1
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !done); // R1
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !start |=> $stable(result)); // R1
  AST_CMP_IS_BOOL: assert property (@(posedge clk) disable iff (!rst_n) (start && is_cmp) |=> result[W-1:1] == '0); // R5
  AST_UNARY_ONE_POP: assert property (@(posedge clk) disable iff (!rst_n) (start && is_unary) |=> !pops_two); // R11
  AST_BAD_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n) bad_op |-> (result == '0 && !pops_two)); // R12
endmodule

// File: tb/tb_stk_alu.sv
module tb_stk_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  op = '0;
  logic [31:0] tos = '0, nos = '0;
  logic        done, pops_two, bad_op;
  logic [31:0] result;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  stk_alu #(.W(32)) dut (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .tos(tos), .nos(nos),
                         .done(done), .result(result), .pops_two(pops_two), .bad_op(bad_op));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [7:0] c, input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] exp, input logic two, input logic bad);
    @(negedge clk);
    op = c; tos = a; nos = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; op = 8'hEE; tos = '1; nos = '1;
    chk({tag, " done"}, 32'(done), 32'd1);
    chk({tag, " result"}, result, exp);
    chk({tag, " pops_two"}, 32'(pops_two), 32'(two));
    chk({tag, " bad_op"}, 32'(bad), 32'(bad_op));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R13 done", 32'(done), 0);
    chk("R13 result", result, 0);
    chk("R13 pops_two", 32'(pops_two), 0);
    chk("R13 bad_op", 32'(bad_op), 0);
  endtask

  task automatic t_arith;
    run("R2 add", 8'd5, 32'd3, 32'd4, 32'd7, 1, 0);
    run("R2 add wrap", 8'd5, 32'hFFFF_FFFF, 32'd1, 32'd0, 1, 0);
    run("R2 sub b-a", 8'd49, 32'd3, 32'd10, 32'd7, 1, 0);
    run("R2 sub negative", 8'd49, 32'd10, 32'd3, 32'hFFFF_FFF9, 1, 0);
    run("R2 neg", 8'd48, 32'd5, 32'd9, 32'hFFFF_FFFB, 0, 0);
    run("R2 neg zero", 8'd48, 32'd0, 32'd9, 32'd0, 0, 0);
  endtask

  task automatic t_logic;
    run("R3 and", 8'd6, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'h00F0_000F, 1, 0);
    run("R3 or", 8'd7, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'hFFF0_0FFF, 1, 0);
    run("R3 xor", 8'd50, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'hFF00_0FF0, 1, 0);
    run("R3 R11 not", 8'd9, 32'h0000_FFFF, 32'h1234_0000, 32'hFFFF_0000, 0, 0);
    run("R4 R11 rev one", 8'd10, 32'd1, 32'd0, 32'h8000_0000, 0, 0);
    run("R4 rev pattern", 8'd10, 32'h1234_5678, 32'd0, 32'h1E6A_2C48, 0, 0);
  endtask

  task automatic t_compare;
    run("R5 lt neg<pos", 8'd36, 32'hFFFF_FFFF, 32'd1, 32'd1, 1, 0);
    run("R5 lt pos<neg", 8'd36, 32'd1, 32'hFFFF_FFFF, 32'd0, 1, 0);
    run("R5 lt equal", 8'd36, 32'd5, 32'd5, 32'd0, 1, 0);
    run("R5 le equal", 8'd37, 32'd5, 32'd5, 32'd1, 1, 0);
    run("R6 ult big<small", 8'd38, 32'hFFFF_FFFF, 32'd1, 32'd0, 1, 0);
    run("R6 ult small<big", 8'd38, 32'd1, 32'hFFFF_FFFF, 32'd1, 1, 0);
    run("R6 ule equal", 8'd39, 32'h8000_0000, 32'h8000_0000, 32'd1, 1, 0);
    run("R6 ule greater", 8'd39, 32'h8000_0001, 32'h8000_0000, 32'd0, 1, 0);
    run("R7 eq same", 8'd46, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'd1, 1, 0);
    run("R7 eq diff", 8'd46, 32'hDEAD_BEEF, 32'hDEAD_BEEE, 32'd0, 1, 0);
    run("R7 ne same", 8'd47, 32'd7, 32'd7, 32'd0, 1, 0);
    run("R7 ne diff", 8'd47, 32'd7, 32'd8, 32'd1, 1, 0);
  endtask

  task automatic t_mul;
    run("R8 mul negative", 8'd41, 32'hFFFF_FFFD, 32'd7, 32'hFFFF_FFEB, 1, 0);
    run("R8 mul low bits", 8'd41, 32'h0001_0000, 32'h0001_0000, 32'd0, 1, 0);
    run("R8 mul plain", 8'd41, 32'd1000, 32'd1000, 32'd1_000_000, 1, 0);
  endtask

  task automatic t_shift;
    run("R9 srl 4", 8'd42, 32'd4, 32'h8000_0000, 32'h0800_0000, 1, 0);
    run("R9 srl 31", 8'd42, 32'd31, 32'h8000_0000, 32'd1, 1, 0);
    run("R9 srl 32", 8'd42, 32'd32, 32'hFFFF_FFFF, 32'd0, 1, 0);
    run("R9 srl mask 0x40", 8'd42, 32'h40, 32'h8000_0000, 32'h8000_0000, 1, 0);
    run("R9 sll 31", 8'd43, 32'd31, 32'd1, 32'h8000_0000, 1, 0);
    run("R9 sll 33", 8'd43, 32'd33, 32'hFFFF_FFFF, 32'd0, 1, 0);
    run("R9 sll mask 0x41", 8'd43, 32'h41, 32'd1, 32'd2, 1, 0);
    run("R10 sra 4", 8'd44, 32'd4, 32'h8000_0000, 32'hF800_0000, 1, 0);
    run("R10 sra 1", 8'd44, 32'd1, 32'h8000_0010, 32'hC000_0008, 1, 0);
    run("R10 sra 40 neg", 8'd44, 32'd40, 32'h8000_0000, 32'hFFFF_FFFF, 1, 0);
    run("R10 sra 63 pos", 8'd44, 32'd63, 32'h7FFF_FFFF, 32'd0, 1, 0);
  endtask

  task automatic t_illegal;
    run("R12 code 0xFF", 8'hFF, 32'd3, 32'd4, 32'd0, 0, 1);
    run("R12 code 0x00", 8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 0, 1);
    run("R12 code 45", 8'd45, 32'd1, 32'd1, 32'd0, 0, 1);
    run("R12 legal clears", 8'd5, 32'd1, 32'd1, 32'd2, 1, 0);
  endtask

  task automatic t_hold;
    run("R1 setup", 8'd5, 32'd100, 32'd23, 32'd123, 1, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R1 done falls", 32'(done), 0);
      chk("R1 result holds", result, 32'd123);
      chk("R1 pops holds", 32'(pops_two), 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_hold();
    t_arith();
    t_logic();
    t_compare();
    t_mul();
    t_shift();
    t_illegal();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule